// File: doc/BRIEF.md
# DS2 AIS Detector

This block watches a serial DS2 bit stream for an alarm indication signal (an all-ones or nearly all-ones stream). A bit-rate strobe marks the clock cycles that carry a valid bit. The strobed bits are cut into back-to-back windows of a fixed length, 840 bits by default. The zeros in each window are counted.

A window with fewer than five zeros is called quiet, and a window with five or more zeros is called busy. The status flag is raised when two consecutive windows are both quiet. It drops when two consecutive windows are both busy. Any other pair leaves the flag as it was, which gives the flag hysteresis. The flag can move only on the clock edge that takes in the last bit of a window.

A block-enable input puts the detector into an idle state. While idle, the flag is held low and all window progress is thrown away. The block is meant to sit beside a DS2 demultiplexer and take the same data and strobe.

Top module: `ds2_ais_monitor`

## Requirements
- R1: While `rst` is high, `ais_o` is low, the window position goes to its first bit and the window history is emptied. The first window begins with the first strobed bit after reset.
- R2: A window is exactly WIN_LEN (840) bits, counted on cycles where `bit_en` is high. On cycles where `bit_en` is low, `bit_in` adds nothing to the zero count or the window position, whatever its value.
- R3: When a quiet window (0 to 4 zeros) follows a quiet window, `ais_o` goes high on the clock edge that takes in the last bit of the second window.
- R4: When a busy window (5 or more zeros) follows a busy window, `ais_o` goes low on the clock edge that takes in the last bit of the second window.
- R5: A quiet window after a busy one, or a busy window after a quiet one, leaves `ais_o` unchanged.
- R6: `ais_o` changes only on an edge where a window closes, or on an edge where the block is idle.
- R7: The threshold is exact. A window with exactly 4 zeros is quiet, and one with exactly 5 zeros is busy.
- R8: While `mon_en` is low, `ais_o` is low from the next edge on. The partial window and the history are discarded. After `mon_en` returns high, the first complete window on its own cannot raise `ais_o`.
- R9: The zero count saturates. Any window with 5 to 840 zeros, including a window of all zeros, is treated as busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Block enable; low makes the detector idle |
| bit_en | input | 1 | Strobe: `bit_in` carries a valid DS2 bit this cycle |
| bit_in | input | 1 | Serial DS2 data |
| ais_o | output | 1 | Registered AIS status flag |

## Verification
The bench targets the 4/5 zero boundary, because a design with an off-by-one threshold would raise or drop the flag one window too early or too late. It feeds mixed quiet/busy pairs, which a design without proper hysteresis would use to toggle the flag. It places idle strobe gaps full of zeros inside windows, which a design that counts unstrobed cycles would wrongly see as busy. It also drops the enable in the middle of a window: a design that keeps its history would then declare AIS after only one quiet window.

// File: rtl/ds2_ais_pkg.sv
package ds2_ais_pkg;

    // Classification of one completed window
    typedef enum logic {
        WIN_QUIET = 1'b0,   // fewer zeros than the limit
        WIN_BUSY  = 1'b1    // limit reached
    } win_cls_e;

    // Memory of the previous window
    typedef enum logic [1:0] {
        HIST_EMPTY = 2'd0,
        HIST_QUIET = 2'd1,
        HIST_BUSY  = 2'd2
    } hist_e;

    // Event raised on the strobe that completes a window
    typedef struct packed {
        logic     close;
        win_cls_e cls;
    } win_evt_t;

    function automatic hist_e cls_to_hist(win_cls_e c);
        return (c == WIN_QUIET) ? HIST_QUIET : HIST_BUSY;
    endfunction

endpackage

// File: rtl/ais_bit_window.sv
module ais_bit_window #(
    parameter int WIN_LEN = 840
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic strobe,
    output logic last_bit
);
    localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WIN_LEN - 1);

    logic [CNT_W-1:0] pos_q;

    assign last_bit = en && strobe && (pos_q == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pos_q <= '0;
        end else if (strobe) begin
            if (pos_q == LAST_POS) pos_q <= '0;
            else                   pos_q <= pos_q + 1'b1;
        end
    end

    // R2
    win_pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS);

    // R2
    win_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !strobe) |=> $stable(pos_q));

endmodule

// File: rtl/ais_zero_tally.sv
module ais_zero_tally
    import ds2_ais_pkg::*;
#(
    parameter int ZERO_LIMIT = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     strobe,
    input  logic     bit_in,
    input  logic     last_bit,
    output win_evt_t evt
);
    localparam int ZW = $clog2(ZERO_LIMIT + 1);
    localparam logic [ZW-1:0] LIM_Z = ZW'(ZERO_LIMIT);

    logic [ZW-1:0] zcnt_q;
    logic [ZW:0]   sum;
    logic [ZW-1:0] zcnt_next;

    always_comb begin
        sum       = {1'b0, zcnt_q} + {{ZW{1'b0}}, ~bit_in};
        zcnt_next = (sum >= {1'b0, LIM_Z}) ? LIM_Z : sum[ZW-1:0];
        evt.close = last_bit;
        evt.cls   = (zcnt_next < LIM_Z) ? WIN_QUIET : WIN_BUSY;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            zcnt_q <= '0;
        end else if (strobe) begin
            zcnt_q <= last_bit ? '0 : zcnt_next;
        end
    end

    // R9
    zero_sat_chk: assert property (@(posedge clk) disable iff (rst)
        zcnt_q <= LIM_Z);

    // R2
    zero_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !strobe) |=> $stable(zcnt_q));

endmodule

// File: rtl/ais_hyst_latch.sv
module ais_hyst_latch
    import ds2_ais_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  win_evt_t evt,
    output logic     ais
);
    hist_e hist_q;
    logic  ais_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hist_q <= HIST_EMPTY;
            ais_q  <= 1'b0;
        end else if (evt.close) begin
            if (hist_q == HIST_QUIET && evt.cls == WIN_QUIET) ais_q <= 1'b1;
            else if (hist_q == HIST_BUSY && evt.cls == WIN_BUSY) ais_q <= 1'b0;
            hist_q <= cls_to_hist(evt.cls);
        end
    end

    assign ais = ais_q;

    // R1
    reset_low_chk: assert property (@(posedge clk)
        rst |=> !ais_q);

    // R3
    declare_chk: assert property (@(posedge clk) disable iff (rst)
        (en && evt.close && evt.cls == WIN_QUIET && hist_q == HIST_QUIET) |=> ais_q);

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (en && evt.close && evt.cls == WIN_BUSY && hist_q == HIST_BUSY) |=> !ais_q);

    // R5
    mixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && evt.close && hist_q != HIST_EMPTY && hist_q != cls_to_hist(evt.cls))
        |=> $stable(ais_q));

    // R6
    boundary_only_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !evt.close) |=> $stable(ais_q));

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ais_q && hist_q == HIST_EMPTY));

endmodule

// File: rtl/ds2_ais_monitor.sv
module ds2_ais_monitor
    import ds2_ais_pkg::*;
#(
    parameter int WIN_LEN    = 840,
    parameter int ZERO_LIMIT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic mon_en,
    input  logic bit_en,
    input  logic bit_in,
    output logic ais_o
);
    logic     last_bit;
    win_evt_t evt;

    ais_bit_window #(.WIN_LEN(WIN_LEN)) u_window (
        .clk      (clk),
        .rst      (rst),
        .en       (mon_en),
        .strobe   (bit_en),
        .last_bit (last_bit)
    );

    ais_zero_tally #(.ZERO_LIMIT(ZERO_LIMIT)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .en       (mon_en),
        .strobe   (bit_en),
        .bit_in   (bit_in),
        .last_bit (last_bit),
        .evt      (evt)
    );

    ais_hyst_latch u_hyst (
        .clk (clk),
        .rst (rst),
        .en  (mon_en),
        .evt (evt),
        .ais (ais_o)
    );

endmodule

// File: tb/ds2_ais_monitor_test.sv
module ds2_ais_monitor_test;
    localparam int WIN = 840;
    localparam int LIM = 5;

    logic clk = 1'b0;
    logic rst, mon_en, bit_en, bit_in;
    logic ais_o;

    int checks = 0;
    int errors = 0;

    // model state: -1 empty, 0 quiet, 1 busy
    int  m_hist = -1;
    logic m_ais = 1'b0;

    always #10 clk = ~clk;

    ds2_ais_monitor #(.WIN_LEN(WIN), .ZERO_LIMIT(LIM)) uut (
        .clk(clk), .rst(rst), .mon_en(mon_en),
        .bit_en(bit_en), .bit_in(bit_in), .ais_o(ais_o)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ais_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int win_class(int zeros);
        return (zeros < LIM) ? 0 : 1;
    endfunction

    function automatic logic next_ais(int hist, int cls, logic cur);
        if (hist == cls) return (cls == 0);
        return cur;
    endfunction

    task automatic send_bit(logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(posedge clk);
        #1;
        bit_en = 1'b0;
    endtask

    task automatic idle_cycle(logic b);
        @(negedge clk);
        bit_en = 1'b0;
        bit_in = b;
        @(posedge clk);
        #1;
    endtask

    // One full window with an exact zero count; gaps put unstrobed zeros between bits
    task automatic run_window(int zeros, bit gaps, string req);
        int left = zeros;
        for (int i = 0; i < WIN; i++) begin
            int rem = WIN - i;
            logic b;
            if (gaps && ($urandom % 4 == 0)) idle_cycle(1'b0);
            b = (int'($urandom % rem) < left) ? 1'b0 : 1'b1;
            if (!b) left--;
            if (i == WIN / 2) chk("R6 mid-window", ais_o, m_ais);
            send_bit(b);
        end
        m_ais  = next_ais(m_hist, win_class(zeros), m_ais);
        m_hist = win_class(zeros);
        chk(req, ais_o, m_ais);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; mon_en = 1'b1; bit_en = 1'b0; bit_in = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", ais_o, 1'b0);
        @(negedge clk); rst = 1'b0;

        run_window(0, 1'b0, "R3 first quiet window alone");
        run_window(4, 1'b0, "R7 four zeros quiet, declare");
        run_window(5, 1'b0, "R5 busy after quiet holds");
        run_window(3, 1'b0, "R5 quiet after busy holds");
        run_window(5, 1'b0, "R7 five zeros busy");
        run_window(WIN, 1'b0, "R9 all-zero window busy, clear");
        run_window(0, 1'b1, "R2 gap zeros ignored");
        run_window(4, 1'b1, "R2 gap zeros ignored, declare");

        // partial window then idle
        for (int i = 0; i < 300; i++) send_bit(1'b1);
        chk("R6 partial window", ais_o, m_ais);
        @(negedge clk); mon_en = 1'b0;
        @(posedge clk); #1;
        chk("R8 idle drops flag", ais_o, 1'b0);
        for (int i = 0; i < 20; i++) send_bit(1'b1);
        chk("R8 idle stays low", ais_o, 1'b0);
        @(negedge clk); mon_en = 1'b1;
        m_hist = -1; m_ais = 1'b0;
        run_window(0, 1'b0, "R8 one window after enable");
        run_window(0, 1'b0, "R3 second quiet window declares");

        // mid-run reset
        for (int i = 0; i < 100; i++) send_bit(1'b0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 reset clears flag", ais_o, 1'b0);
        @(negedge clk); rst = 1'b0;
        m_hist = -1; m_ais = 1'b0;
        run_window(1, 1'b0, "R1 fresh window after reset");
        run_window(2, 1'b0, "R3 declare after reset");
        run_window(6, 1'b0, "R5 busy holds");
        run_window(7, 1'b1, "R4 clear on second busy");

        for (int w = 0; w < 14; w++) begin
            int sel = int'($urandom % 3);
            int z;
            if (sel == 0)      z = int'($urandom % 5);
            else if (sel == 1) z = 5 + int'($urandom % 5);
            else               z = int'($urandom % (WIN + 1));
            run_window(z, 1'($urandom % 2), "R3/R4 random window");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule